// File: doc/BRIEF.md
# Counter CSR Access Permission Checker

This combinational block decides the outcome of a read of a user-level counter CSR. It takes the CSR number and the hart's execution context: privilege level, virtualization flag and 32-bit or 64-bit register width. It also takes the counter configuration: which counters are present, how many programmable counters are implemented, and the machine-level and hypervisor-level counter-enable registers. From these it returns one of three outcomes: the access proceeds, the access raises an illegal-instruction exception, or the access raises a virtual-instruction fault.

The block sits beside the CSR decode stage. The counters and the read data path belong to other logic. The cycle, time and instret counters are always present, so they do not consult the availability mask. Under virtualization, a denial by the hypervisor enable register is reported as a virtual-instruction fault and not as an illegal instruction.

Top module: `cnt_csr_access_chk`

## Requirements
- R1: The low window is CSR 0xC00 to 0xC1F and the high window is 0xC80 to 0xC9F. The counter index is the CSR number minus 0xC00 in the low window and minus 0xC80 in the high window. A CSR number outside both windows yields none.
- R2: `result_o` encodes none as 2'b00, illegal as 2'b01 and virtual fault as 2'b10. It never takes 2'b11. The checks apply in the order R3, R5, R6, R7, and the first rule that fires decides the result.
- R3: A high-window CSR accessed with `xlen32_i`=0 (64-bit mode) yields illegal.
- R4: Indices 0, 1 and 2 (cycle, time, instret) ignore `avail_i` and `num_ctrs_i`.
- R5: For an index of 3 or more, the result is illegal when `num_ctrs_i` is 0 or when bit index of `avail_i` is 0.
- R6: With `priv_i`=2'b01 (supervisor), virtualized or not, the result is illegal when bit index of `mcounteren_i` is 0.
- R7: With `virt_i`=1, the result is a virtual fault when bit index of `hcounteren_i` is 0 and bit index of `mcounteren_i` is 1.
- R8: With `priv_i`=2'b11 (machine), the result is none once R3 and R5 have passed, whatever the enable registers hold.
- R9: With `priv_i`=2'b00 (user), the result is none when none of R3, R5 and R7 fires. This includes a virtualized user access with both enable bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_num_i | input | 12 | CSR number being read |
| priv_i | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| virt_i | input | 1 | Virtualization active |
| xlen32_i | input | 1 | 1 when the hart runs in 32-bit mode |
| avail_i | input | 32 | Per-index counter presence mask |
| num_ctrs_i | input | 6 | Number of programmable counters implemented |
| mcounteren_i | input | 32 | Machine counter-enable register |
| hcounteren_i | input | 32 | Hypervisor counter-enable register |
| result_o | output | 2 | Access outcome |

## Verification
The assertions take for granted that `priv_i` never carries the reserved code 2'b10. They also take for granted that `virt_i` is 0 whenever `priv_i` is machine, because a machine-level access is never virtualized. The stimulus respects both conditions by sweeping only five legal contexts: user, supervisor and machine without virtualization, plus user and supervisor with virtualization. These contexts are crossed with every CSR in both windows, with CSR numbers just outside each window, with both register widths and with configuration patterns that include zero implemented counters.

// File: rtl/cnt_acc_pkg.sv
package cnt_acc_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_ILL   = 2'b01,
    ACC_VFLT  = 2'b10
  } acc_result_e;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;
endpackage

// File: rtl/cnt_csr_decode.sv
module cnt_csr_decode #(
  parameter int                CSR_W   = 12,
  parameter int                NUM_CTR = 32,
  parameter int                NUM_FIX = 3,
  parameter logic [CSR_W-1:0]  LO_BASE = 12'hC00,
  parameter logic [CSR_W-1:0]  HI_BASE = 12'hC80,
  localparam int               IDX_W   = $clog2(NUM_CTR)
) (
  input  logic [CSR_W-1:0] csr_num_i,
  input  logic             xlen32_i,
  output logic             hit_o,
  output logic             bad_width_o,
  output logic             fixed_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [CSR_W-1:0] LO_LAST = CSR_W'(int'(LO_BASE) + NUM_CTR - 1);
  localparam logic [CSR_W-1:0] HI_LAST = CSR_W'(int'(HI_BASE) + NUM_CTR - 1);

  logic             lo_hit, hi_hit;
  logic [CSR_W-1:0] lo_off, hi_off;

  always_comb begin
    lo_hit = (csr_num_i >= LO_BASE) && (csr_num_i <= LO_LAST);
    hi_hit = (csr_num_i >= HI_BASE) && (csr_num_i <= HI_LAST);
    lo_off = csr_num_i - LO_BASE;
    hi_off = csr_num_i - HI_BASE;
    hit_o  = lo_hit || hi_hit;
    idx_o  = hi_hit ? hi_off[IDX_W-1:0] : lo_off[IDX_W-1:0];
    // high halves exist only in 32-bit mode
    bad_width_o = hi_hit && !xlen32_i;
    fixed_o     = idx_o < IDX_W'(NUM_FIX);
  end
endmodule

// File: rtl/cnt_avail_check.sv
module cnt_avail_check #(
  parameter  int NUM_CTR = 32,
  localparam int IDX_W   = $clog2(NUM_CTR),
  localparam int NUM_W   = $clog2(NUM_CTR + 1)
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               fixed_i,
  input  logic [NUM_CTR-1:0] avail_i,
  input  logic [NUM_W-1:0]   num_ctrs_i,
  output logic               deny_o
);
  always_comb begin
    deny_o = !fixed_i && ((num_ctrs_i == '0) || !avail_i[idx_i]);
  end
endmodule

// File: rtl/cnt_enable_gate.sv
module cnt_enable_gate
  import cnt_acc_pkg::*;
#(
  parameter  int NUM_CTR = 32,
  localparam int IDX_W   = $clog2(NUM_CTR)
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic [NUM_CTR-1:0] men_i,
  input  logic [NUM_CTR-1:0] hen_i,
  output logic               ill_o,
  output logic               vflt_o
);
  logic m_bit, h_bit, is_s, is_m;

  always_comb begin
    m_bit  = men_i[idx_i];
    h_bit  = hen_i[idx_i];
    is_s   = priv_i == PRIV_S;
    is_m   = priv_i == PRIV_M;
    ill_o  = is_s && !m_bit;
    vflt_o = virt_i && !is_m && !h_bit && m_bit;
  end
endmodule

// File: rtl/cnt_csr_access_chk.sv
module cnt_csr_access_chk
  import cnt_acc_pkg::*;
#(
  parameter  int NUM_CTR = 32,
  parameter  int CSR_W   = 12,
  parameter  int NUM_FIX = 3,
  localparam int IDX_W   = $clog2(NUM_CTR),
  localparam int NUM_W   = $clog2(NUM_CTR + 1)
) (
  input  logic [CSR_W-1:0]   csr_num_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               xlen32_i,
  input  logic [NUM_CTR-1:0] avail_i,
  input  logic [NUM_W-1:0]   num_ctrs_i,
  input  logic [NUM_CTR-1:0] mcounteren_i,
  input  logic [NUM_CTR-1:0] hcounteren_i,
  output logic [1:0]         result_o
);
  logic             hit, bad_width, fixed, avail_deny, en_ill, en_vflt;
  logic [IDX_W-1:0] idx;
  acc_result_e      res;

  cnt_csr_decode #(
    .CSR_W   (CSR_W),
    .NUM_CTR (NUM_CTR),
    .NUM_FIX (NUM_FIX),
    .LO_BASE (CSR_W'(12'hC00)),
    .HI_BASE (CSR_W'(12'hC80))
  ) u_decode (
    .csr_num_i   (csr_num_i),
    .xlen32_i    (xlen32_i),
    .hit_o       (hit),
    .bad_width_o (bad_width),
    .fixed_o     (fixed),
    .idx_o       (idx)
  );

  cnt_avail_check #(.NUM_CTR(NUM_CTR)) u_avail (
    .idx_i      (idx),
    .fixed_i    (fixed),
    .avail_i    (avail_i),
    .num_ctrs_i (num_ctrs_i),
    .deny_o     (avail_deny)
  );

  cnt_enable_gate #(.NUM_CTR(NUM_CTR)) u_gate (
    .idx_i  (idx),
    .priv_i (priv_i),
    .virt_i (virt_i),
    .men_i  (mcounteren_i),
    .hen_i  (hcounteren_i),
    .ill_o  (en_ill),
    .vflt_o (en_vflt)
  );

  always_comb begin
    if (!hit)            res = ACC_NONE;
    else if (bad_width)  res = ACC_ILL;
    else if (avail_deny) res = ACC_ILL;
    else if (en_ill)     res = ACC_ILL;
    else if (en_vflt)    res = ACC_VFLT;
    else                 res = ACC_NONE;
    result_o = res;
  end
endmodule

// File: rtl/cnt_csr_access_chk_sva.sv
module cnt_csr_access_chk_sva #(
  parameter  int NUM_CTR = 32,
  parameter  int CSR_W   = 12,
  localparam int NUM_W   = $clog2(NUM_CTR + 1)
) (
  input logic [CSR_W-1:0]   csr_num_i,
  input logic [1:0]         priv_i,
  input logic               virt_i,
  input logic               xlen32_i,
  input logic [NUM_CTR-1:0] avail_i,
  input logic [NUM_W-1:0]   num_ctrs_i,
  input logic [NUM_CTR-1:0] mcounteren_i,
  input logic [NUM_CTR-1:0] hcounteren_i,
  input logic [1:0]         result_o
);
  logic in_lo, in_hi;
  int   ix;

  always_comb begin
    in_lo = (csr_num_i >= CSR_W'(12'hC00)) && (csr_num_i <= CSR_W'(12'hC1F));
    in_hi = (csr_num_i >= CSR_W'(12'hC80)) && (csr_num_i <= CSR_W'(12'hC9F));
    ix    = int'(csr_num_i[4:0]);

    AST_RESULT_CODE: assert (result_o != 2'b11) else $error("illegal result code"); // R2
    AST_OUTSIDE_NONE: assert (in_lo || in_hi || result_o == 2'b00)
      else $error("outside window not none"); // R1
    AST_HIGH_WIDE_ILL: assert (!(in_hi && !xlen32_i) || result_o == 2'b01)
      else $error("high half in 64-bit mode allowed"); // R3
    AST_PROG_UNAVAIL: assert (!(in_lo && ix >= 3 && (num_ctrs_i == '0 || !avail_i[ix[4:0]]))
                              || result_o == 2'b01)
      else $error("unavailable counter allowed"); // R5
    AST_VFLT_NEEDS_VIRT: assert (result_o != 2'b10 || (virt_i && priv_i != 2'b11))
      else $error("virtual fault without virtualization"); // R7
    AST_MACHINE_PASS: assert (!(priv_i == 2'b11 && in_lo && ix < 3) || result_o == 2'b00)
      else $error("machine fixed counter denied"); // R8
  end
endmodule

bind cnt_csr_access_chk cnt_csr_access_chk_sva #(
  .NUM_CTR (NUM_CTR),
  .CSR_W   (CSR_W)
) u_sva (.*);

// File: tb/cnt_csr_access_chk_tb_top.sv
module cnt_csr_access_chk_tb_top;
  logic        clk;
  logic [11:0] csr_num;
  logic [1:0]  priv;
  logic        virt, xlen32;
  logic [31:0] avail, men, hen;
  logic [5:0]  num_ctrs;
  logic [1:0]  result;
  int          n_cmp, n_bad;
  bit          done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  cnt_csr_access_chk dut_i (
    .csr_num_i    (csr_num),
    .priv_i       (priv),
    .virt_i       (virt),
    .xlen32_i     (xlen32),
    .avail_i      (avail),
    .num_ctrs_i   (num_ctrs),
    .mcounteren_i (men),
    .hcounteren_i (hen),
    .result_o     (result)
  );

  // independent reference; tag names the deciding requirement
  function automatic logic [1:0] ref_result(input logic [11:0] c, input logic [1:0] p,
      input logic v, input logic x32, input logic [31:0] av, input logic [5:0] nc,
      input logic [31:0] me, input logic [31:0] he, output string tag);
    int  i;
    bit  lo, hi;
    lo = (c >= 12'hC00) && (c < 12'hC20);
    hi = (c >= 12'hC80) && (c < 12'hCA0);
    if (!lo && !hi) begin tag = "R1"; return 2'b00; end
    i = hi ? int'(c) - 'hC80 : int'(c) - 'hC00;
    if (hi && !x32) begin tag = "R3"; return 2'b01; end
    if (i >= 3 && (nc == 0 || !av[i])) begin tag = "R5"; return 2'b01; end
    if (p == 2'b01 && !me[i]) begin tag = "R6"; return 2'b01; end
    if (v && !he[i] && me[i]) begin tag = "R7"; return 2'b10; end
    if (p == 2'b11) tag = "R8";
    else if (i < 3) tag = "R4";
    else tag = "R9";
    return 2'b00;
  endfunction

  task automatic apply_check(input logic [11:0] c, input logic [1:0] p, input logic v,
      input logic x32, input logic [31:0] av, input logic [5:0] nc,
      input logic [31:0] me, input logic [31:0] he);
    logic [1:0] exp;
    string      tag;
    @(posedge clk);
    #1;
    csr_num = c; priv = p; virt = v; xlen32 = x32;
    avail = av; num_ctrs = nc; men = me; hen = he;
    exp = ref_result(c, p, v, x32, av, nc, me, he, tag);
    @(negedge clk);
    n_cmp++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s csr=%h priv=%0d virt=%0b x32=%0b got=%b exp=%b",
               tag, c, p, v, x32, result, exp);
    end
  endtask

  logic [31:0] cfg_av [6];
  logic [5:0]  cfg_nc [6];
  logic [31:0] cfg_me [6];
  logic [31:0] cfg_he [6];
  logic [1:0]  md_p   [5];
  logic        md_v   [5];
  logic [11:0] outside [6];

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    csr_num = '0; priv = '0; virt = 1'b0; xlen32 = 1'b0;
    avail = '0; num_ctrs = '0; men = '0; hen = '0;
    cfg_av = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0F0F_F0F0};
    cfg_nc = '{6'd29,          6'd0,          6'd16,         6'd8,          6'd1,          6'd29};
    cfg_me = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hCCCC_CCCC, 32'h3333_3333, 32'hFFFF_0000};
    cfg_he = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h00FF_FF00};
    md_p = '{2'b00, 2'b01, 2'b11, 2'b00, 2'b01};
    md_v = '{1'b0,  1'b0,  1'b0,  1'b1,  1'b1};
    outside = '{12'hBFF, 12'hC20, 12'hC7F, 12'hCA0, 12'h000, 12'hFFF};

    // idle state: CSR 0 is outside the windows, so R1 gives none
    @(negedge clk);
    n_cmp++;
    if (result !== 2'b00) begin
      n_bad++;
      $display("FAIL R1 idle got=%b exp=00", result);
    end

    for (int k = 0; k < 6; k++)
      for (int m = 0; m < 5; m++)
        for (int w = 0; w < 2; w++) begin
          for (int c = 0; c < 64; c++)
            apply_check((c < 32) ? 12'(12'hC00 + c) : 12'(12'hC80 + c - 32),
                        md_p[m], md_v[m], w[0], cfg_av[k], cfg_nc[k], cfg_me[k], cfg_he[k]);
          for (int o = 0; o < 6; o++)
            apply_check(outside[o], md_p[m], md_v[m], w[0],
                        cfg_av[k], cfg_nc[k], cfg_me[k], cfg_he[k]);
        end
    // R2 priority: 64-bit high half wins over every later rule
    apply_check(12'hC85, 2'b01, 1'b1, 1'b0, 32'h0, 6'd0, 32'h0, 32'h0);
    // R4: fixed counters with nothing available in machine mode
    apply_check(12'hC01, 2'b11, 1'b0, 1'b0, 32'h0, 6'd0, 32'h0, 32'h0);
    // R9: virtualized user with both enables clear passes
    apply_check(12'hC02, 2'b00, 1'b1, 1'b0, 32'h0, 6'd0, 32'h0, 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule